// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A requester presents the virtual address, the access kind (read or write, privileged or user), the table base and the domain access word. The walker fetches the first-level descriptor, fetches a second-level descriptor when the first level points to a table, and then runs the domain and permission checks. It returns the physical address, the cacheable and bufferable attributes and a fault code, all for one cycle.

Memory is reached through one word-read port. A request is held until the memory accepts it. The response comes back with a valid strobe at least one cycle after acceptance. Only one walk runs at a time. A new request is taken only while the walker is idle.

Top module: `xlat_walker`

## Requirements
- R1: The first memory read of a walk goes to address {tbase[31:14], va[31:20], 2'b00}, and its request is issued in the cycle after the walk is accepted.
- R2: The first-level descriptor type sits in bits [1:0]. 00 ends the walk with fault code 1 (section translation) after a single read. 10 is a 1 MB section whose physical address is {desc[31:20], va[19:0]}, also after a single read.
- R3: Type 01 selects a coarse table, and the second read goes to {desc[31:10], va[19:12], 2'b00}. Type 11 selects a fine table, and the second read goes to {desc[31:12], va[19:10], 2'b00}.
- R4: The second-level descriptor type sits in bits [1:0]. 00 gives fault code 2 (page translation). 01 is a large page with address {desc[31:16], va[15:0]}. 10 is a small page with address {desc[31:12], va[11:0]}. 11 is a tiny page with address {desc[31:10], va[9:0]}.
- R5: The cacheable output is bit 3 and the bufferable output is bit 2 of the final descriptor: the section descriptor for a section, otherwise the second-level descriptor.
- R6: The domain number is taken from bits [8:5] of the first-level descriptor, and the domain access word holds 2 bits per domain at position 2*domain. A field of 00 or 10 faults with code 3 for a section or code 4 for a page. A field of 11 skips the permission check. A field of 01 applies the permission check.
- R7: The permission field is bits [11:10] for a section. For a large page it is bits [2k+5:2k+4] with k = va[15:14]. For a small page k = va[11:10]. A tiny page uses bits [5:4]. The access is allowed as follows. Code 00 allows privileged reads only. Code 01 allows privileged reads and writes. Code 10 also allows user reads. Code 11 allows everything. A denied access gives code 5 for a section or code 6 for a page.
- R8: Translation faults take precedence over domain faults, and domain faults over permission faults. On any fault the physical address, cacheable and bufferable outputs are zero. Without a fault the code is 0.
- R9: `req_ready` is high only while idle. A request presented during a walk is ignored: it does not change the result and starts no further reads.
- R10: `done` is high for exactly one cycle per walk. The walker is ready again in the next cycle.
- R11: While a memory request waits for `mem_req_ready`, it stays valid with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access |
| req_priv | input | 1 | 1 for a privileged access |
| tbase | input | 32 | First-level table base (bits [31:14] used) |
| dacr | input | 32 | Domain access word, 2 bits per domain |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word address to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | Result valid, one cycle |
| pa | output | 32 | Physical address |
| cacheable | output | 1 | Cacheable attribute |
| bufferable | output | 1 | Bufferable attribute |
| fault_code | output | 3 | 0 none, 1..6 as in R2, R4, R6, R7 |

## Verification
The hardest situations to reach are the subpage permission selection inside large pages and the choice between coarse and fine tables. Each needs a consistent pair of descriptors in memory, and the virtual address must index the right table slot and select the right permission quarter. The bench builds a sparse memory in which one large-page descriptor is repeated in every slot its quarters index. It then walks addresses through each quarter, each table kind and each domain class with both access kinds. Memory readiness and response latency follow a rotating pattern, so the request hold and the single-cycle result are exercised under stalls. A request kept asserted during a walk checks that a busy walker ignores it.

// File: rtl/xw_pkg.sv
`timescale 1ns/1ps
package xw_pkg;

   typedef enum logic [2:0] {
      FLT_NONE      = 3'd0,
      FLT_SEC_XLAT  = 3'd1,
      FLT_PAGE_XLAT = 3'd2,
      FLT_SEC_DOM   = 3'd3,
      FLT_PAGE_DOM  = 3'd4,
      FLT_SEC_PERM  = 3'd5,
      FLT_PAGE_PERM = 3'd6
   } xw_fault_e;

   typedef enum logic [1:0] {
      L1K_FAULT   = 2'b00,
      L1K_COARSE  = 2'b01,
      L1K_SECTION = 2'b10,
      L1K_FINE    = 2'b11
   } xw_l1_kind_e;

   typedef enum logic [1:0] {
      L2K_FAULT = 2'b00,
      L2K_LARGE = 2'b01,
      L2K_SMALL = 2'b10,
      L2K_TINY  = 2'b11
   } xw_l2_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_L1_REQ = 3'd1,
      ST_L1_RSP = 3'd2,
      ST_L2_REQ = 3'd3,
      ST_L2_RSP = 3'd4,
      ST_DONE   = 3'd5
   } xw_state_e;

endpackage

// File: rtl/xw_l1_decode.sv
`timescale 1ns/1ps
module xw_l1_decode
   import xw_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned DOM_W = 4,
   parameter int unsigned AP_W  = 2
) (
   input  logic [AW-1:0]    desc,
   input  logic [19:0]      va_lo,
   output xw_l1_kind_e      kind,
   output logic [AW-1:0]    sec_pa,
   output logic [AW-1:0]    l2_addr,
   output logic [DOM_W-1:0] dom,
   output logic [AP_W-1:0]  sec_ap,
   output logic             cbit,
   output logic             bbit
);
   localparam int unsigned SEC_SH  = 20;
   localparam int unsigned CRS_SH  = 10;
   localparam int unsigned FIN_SH  = 12;
   localparam int unsigned DOM_LSB = 5;
   localparam int unsigned AP_LSB  = 10;

   if (AW != 32) begin : g_aw_chk
      $error("xw_l1_decode: AW must be 32");
   end
   if (DOM_LSB + DOM_W > AP_LSB - 1) begin : g_dom_chk
      $error("xw_l1_decode: domain field overlaps");
   end

   logic [AW-1:0] coarse_addr;
   logic [AW-1:0] fine_addr;
   logic          unused_l1;

   assign kind        = xw_l1_kind_e'(desc[1:0]);
   assign sec_pa      = {desc[AW-1:SEC_SH], va_lo[SEC_SH-1:0]};
   assign coarse_addr = {desc[AW-1:CRS_SH], va_lo[SEC_SH-1:FIN_SH], 2'b00};
   assign fine_addr   = {desc[AW-1:FIN_SH], va_lo[SEC_SH-1:CRS_SH], 2'b00};
   assign l2_addr     = desc[1] ? fine_addr : coarse_addr;
   assign dom         = desc[DOM_LSB +: DOM_W];
   assign sec_ap      = desc[AP_LSB +: AP_W];
   assign cbit        = desc[3];
   assign bbit        = desc[2];
   assign unused_l1   = ^{desc[4], desc[9]};

endmodule

// File: rtl/xw_l2_decode.sv
`timescale 1ns/1ps
module xw_l2_decode
   import xw_pkg::*;
#(
   parameter int unsigned AW   = 32,
   parameter int unsigned AP_W = 2,
   parameter int unsigned NSUB = 4
) (
   input  logic [AW-1:0]   desc,
   input  logic [15:0]     va_lo,
   output xw_l2_kind_e     kind,
   output logic [AW-1:0]   pa,
   output logic [AP_W-1:0] ap,
   output logic            cbit,
   output logic            bbit
);
   localparam int unsigned SEL_W  = $clog2(NSUB);
   localparam int unsigned AP_LSB = 4;
   localparam int unsigned LRG_SH = 16;
   localparam int unsigned SML_SH = 12;
   localparam int unsigned TNY_SH = 10;

   if (NSUB != 4 || AP_W != 2) begin : g_sub_chk
      $error("xw_l2_decode: four 2-bit subpage fields required");
   end
   if (AW != 32) begin : g_aw_chk
      $error("xw_l2_decode: AW must be 32");
   end

   logic [AP_W-1:0]  sub_ap [NSUB];
   logic [SEL_W-1:0] sel;

   for (genvar i = 0; i < NSUB; i++) begin : g_sub
      assign sub_ap[i] = desc[AP_LSB + AP_W*i +: AP_W];
   end

   assign kind = xw_l2_kind_e'(desc[1:0]);
   assign cbit = desc[3];
   assign bbit = desc[2];

   always_comb begin
      sel = '0;
      pa  = '0;
      unique case (kind)
         L2K_LARGE: begin
            sel = va_lo[LRG_SH-1 -: SEL_W];
            pa  = {desc[AW-1:LRG_SH], va_lo[LRG_SH-1:0]};
         end
         L2K_SMALL: begin
            sel = va_lo[SML_SH-1 -: SEL_W];
            pa  = {desc[AW-1:SML_SH], va_lo[SML_SH-1:0]};
         end
         L2K_TINY: begin
            sel = '0;
            pa  = {desc[AW-1:TNY_SH], va_lo[TNY_SH-1:0]};
         end
         default: begin
            sel = '0;
            pa  = '0;
         end
      endcase
   end

   assign ap = sub_ap[sel];

endmodule

// File: rtl/xw_perm_check.sv
`timescale 1ns/1ps
module xw_perm_check
   import xw_pkg::*;
#(
   parameter int unsigned DOM_W = 4,
   parameter int unsigned AP_W  = 2,
   localparam int unsigned NDOM   = 1 << DOM_W,
   localparam int unsigned DACR_W = 2 * NDOM
) (
   input  logic [DACR_W-1:0] dacr,
   input  logic [DOM_W-1:0]  dom,
   input  logic [AP_W-1:0]   ap,
   input  logic              wr,
   input  logic              priv,
   input  logic              is_page,
   output xw_fault_e         fault
);
   if (AP_W != 2) begin : g_ap_chk
      $error("xw_perm_check: permission field must be 2 bits");
   end

   logic [1:0] dfield [NDOM];
   logic [1:0] dsel;
   logic       allow;

   for (genvar d = 0; d < NDOM; d++) begin : g_dom
      assign dfield[d] = dacr[2*d +: 2];
   end

   assign dsel = dfield[dom];

   always_comb begin
      unique case (ap)
         2'b00:   allow = priv & ~wr;
         2'b01:   allow = priv;
         2'b10:   allow = priv | ~wr;
         default: allow = 1'b1;
      endcase
   end

   always_comb begin
      fault = FLT_NONE;
      unique case (dsel)
         2'b01: begin
            if (!allow) fault = is_page ? FLT_PAGE_PERM : FLT_SEC_PERM;
         end
         2'b11:   fault = FLT_NONE;
         default: fault = is_page ? FLT_PAGE_DOM : FLT_SEC_DOM;
      endcase
   end

endmodule

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker
   import xw_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned DOM_W = 4,
   parameter int unsigned AP_W  = 2,
   localparam int unsigned DACR_W = 2 * (1 << DOM_W),
   localparam int unsigned TB_SH  = 14,
   localparam int unsigned IDX_SH = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [AW-1:0]     req_va,
   input  logic              req_write,
   input  logic              req_priv,
   input  logic [AW-1:0]     tbase,
   input  logic [DACR_W-1:0] dacr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [AW-1:0]     mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [AW-1:0]     mem_rsp_data,
   output logic              done,
   output logic [AW-1:0]     pa,
   output logic              cacheable,
   output logic              bufferable,
   output logic [2:0]        fault_code
);
   if (AW != 32) begin : g_aw_chk
      $error("xlat_walker: AW must be 32");
   end
   if (DACR_W != 32) begin : g_dacr_chk
      $error("xlat_walker: domain access word must be 32 bits");
   end

   xw_state_e             st_q, st_d;
   logic [AW-1:0]         va_q;
   logic [AW-TB_SH-1:0]   tb_q;
   logic [DACR_W-1:0]     dacr_q;
   logic [AW-1:0]         l1_q;
   logic                  wr_q, pr_q;
   logic [AW-1:0]         pa_q;
   logic                  c_q, b_q;
   xw_fault_e             flt_q;

   logic                  accept;
   logic [AW-1:0]         l1_src;
   logic [AW-1:0]         l1_fetch_addr;

   xw_l1_kind_e           l1_kind;
   logic [AW-1:0]         l1_sec_pa, l1_l2_addr;
   logic [DOM_W-1:0]      l1_dom;
   logic [AP_W-1:0]       l1_ap;
   logic                  l1_c, l1_b;

   xw_l2_kind_e           l2_kind;
   logic [AW-1:0]         l2_pa;
   logic [AP_W-1:0]       l2_ap;
   logic                  l2_c, l2_b;

   logic                  chk_page;
   logic [AP_W-1:0]       chk_ap;
   xw_fault_e             chk_fault;

   logic                  res_load;
   logic [AW-1:0]         res_pa;
   logic                  res_c, res_b;
   xw_fault_e             res_f;

   assign accept        = req_valid && (st_q == ST_IDLE);
   assign l1_src        = (st_q == ST_L1_RSP) ? mem_rsp_data : l1_q;
   assign l1_fetch_addr = {tb_q, va_q[AW-1:IDX_SH], 2'b00};

   xw_l1_decode #(.AW(AW), .DOM_W(DOM_W), .AP_W(AP_W)) u_l1 (
      .desc    (l1_src),
      .va_lo   (va_q[19:0]),
      .kind    (l1_kind),
      .sec_pa  (l1_sec_pa),
      .l2_addr (l1_l2_addr),
      .dom     (l1_dom),
      .sec_ap  (l1_ap),
      .cbit    (l1_c),
      .bbit    (l1_b)
   );

   xw_l2_decode #(.AW(AW), .AP_W(AP_W), .NSUB(4)) u_l2 (
      .desc  (mem_rsp_data),
      .va_lo (va_q[15:0]),
      .kind  (l2_kind),
      .pa    (l2_pa),
      .ap    (l2_ap),
      .cbit  (l2_c),
      .bbit  (l2_b)
   );

   assign chk_page = (st_q == ST_L2_RSP);
   assign chk_ap   = chk_page ? l2_ap : l1_ap;

   xw_perm_check #(.DOM_W(DOM_W), .AP_W(AP_W)) u_perm (
      .dacr    (dacr_q),
      .dom     (l1_dom),
      .ap      (chk_ap),
      .wr      (wr_q),
      .priv    (pr_q),
      .is_page (chk_page),
      .fault   (chk_fault)
   );

   always_comb begin
      st_d     = st_q;
      res_load = 1'b0;
      res_pa   = '0;
      res_c    = 1'b0;
      res_b    = 1'b0;
      res_f    = FLT_NONE;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid) st_d = ST_L1_REQ;
         end
         ST_L1_REQ: begin
            if (mem_req_ready) st_d = ST_L1_RSP;
         end
         ST_L1_RSP: begin
            if (mem_rsp_valid) begin
               unique case (l1_kind)
                  L1K_FAULT: begin
                     res_load = 1'b1;
                     res_f    = FLT_SEC_XLAT;
                     st_d     = ST_DONE;
                  end
                  L1K_SECTION: begin
                     res_load = 1'b1;
                     res_f    = chk_fault;
                     if (chk_fault == FLT_NONE) begin
                        res_pa = l1_sec_pa;
                        res_c  = l1_c;
                        res_b  = l1_b;
                     end
                     st_d = ST_DONE;
                  end
                  default: st_d = ST_L2_REQ;
               endcase
            end
         end
         ST_L2_REQ: begin
            if (mem_req_ready) st_d = ST_L2_RSP;
         end
         ST_L2_RSP: begin
            if (mem_rsp_valid) begin
               res_load = 1'b1;
               if (l2_kind == L2K_FAULT) begin
                  res_f = FLT_PAGE_XLAT;
               end else begin
                  res_f = chk_fault;
                  if (chk_fault == FLT_NONE) begin
                     res_pa = l2_pa;
                     res_c  = l2_c;
                     res_b  = l2_b;
                  end
               end
               st_d = ST_DONE;
            end
         end
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         va_q   <= '0;
         tb_q   <= '0;
         dacr_q <= '0;
         wr_q   <= 1'b0;
         pr_q   <= 1'b0;
         l1_q   <= '0;
         pa_q   <= '0;
         c_q    <= 1'b0;
         b_q    <= 1'b0;
         flt_q  <= FLT_NONE;
      end else begin
         st_q <= st_d;
         if (accept) begin
            va_q   <= req_va;
            tb_q   <= tbase[AW-1:TB_SH];
            dacr_q <= dacr;
            wr_q   <= req_write;
            pr_q   <= req_priv;
         end
         if (st_q == ST_L1_RSP && mem_rsp_valid) l1_q <= mem_rsp_data;
         if (res_load) begin
            pa_q  <= res_pa;
            c_q   <= res_c;
            b_q   <= res_b;
            flt_q <= res_f;
         end
      end
   end

   assign req_ready     = (st_q == ST_IDLE);
   assign mem_req_valid = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
   assign mem_req_addr  = (st_q == ST_L2_REQ) ? l1_l2_addr : l1_fetch_addr;
   assign done          = (st_q == ST_DONE);
   assign pa            = pa_q;
   assign cacheable     = c_q;
   assign bufferable    = b_q;
   assign fault_code    = flt_q;

   // R1: first fetch follows acceptance with the table-entry address
   p_l1_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_req_valid &&
         mem_req_addr == {$past(tbase[AW-1:TB_SH]), $past(req_va[AW-1:IDX_SH]), 2'b00}));

   // R8: faults clear the translation outputs
   p_fault_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault_code != 3'd0) |-> (pa == '0 && !cacheable && !bufferable));

   // R9: an accepted request makes the walker busy
   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R10: single-cycle result followed by idle
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));

   // R11: a stalled memory request holds
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

// File: tb/xlat_walker_tb_top.sv
`timescale 1ns/1ps
module xlat_walker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_va;
   logic        req_write;
   logic        req_priv;
   logic [31:0] tbase;
   logic [31:0] dacr;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        done;
   logic [31:0] pa;
   logic        cacheable;
   logic        bufferable;
   logic [2:0]  fault_code;

   always #10 clk = ~clk;

   xlat_walker dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .req_write(req_write), .req_priv(req_priv),
      .tbase(tbase), .dacr(dacr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data),
      .done(done), .pa(pa), .cacheable(cacheable), .bufferable(bufferable),
      .fault_code(fault_code)
   );

   bit [31:0]   mem [bit [31:0]];
   logic [31:0] addr_q [$];
   int          n_run  = 0;
   int          n_fail = 0;
   int          cyc    = 0;
   bit          pend   = 0;
   int          lat    = 0;
   logic [31:0] hold   = '0;
   logic        done_prev = 1'b0;

   localparam logic [31:0] TB = 32'h0010_0000;
   localparam logic [31:0] CB = 32'h0020_0400;
   localparam logic [31:0] FB = 32'h0030_1000;

   function automatic bit [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic bit [31:0] mk_l1(input bit [1:0] t, input bit [31:0] base,
                                       input int dm, input bit [1:0] ap,
                                       input bit c, input bit b);
      return base | (32'(ap) << 10) | (32'(dm) << 5) | (32'(c) << 3) | (32'(b) << 2) | 32'(t);
   endfunction

   function automatic bit [31:0] mk_l2(input bit [1:0] t, input bit [31:0] frame,
                                       input bit [7:0] aps, input bit c, input bit b);
      return frame | (32'(aps) << 4) | (32'(c) << 3) | (32'(b) << 2) | 32'(t);
   endfunction

   // Behavioural model of a whole walk, written from the requirements
   function automatic void ref_walk(input logic [31:0] va, input bit wr, input bit pr,
                                    output logic [31:0] epa, output bit ec, output bit eb,
                                    output logic [2:0] ef, output logic [31:0] a1,
                                    output logic [31:0] a2, output int n);
      bit [31:0] d, e;
      int        dm;
      bit [1:0]  apf, dc;
      bit        pg, ok;
      epa = 0; ec = 0; eb = 0; ef = 0; n = 1; a2 = 0; apf = 0; pg = 0;
      a1 = {TB[31:14], va[31:20], 2'b00};
      d  = rd(a1);
      if (d[1:0] == 2'b00) begin ef = 3'd1; return; end
      dm = int'(d[8:5]);
      if (d[1:0] == 2'b10) begin
         apf = d[11:10]; epa = {d[31:20], va[19:0]}; ec = d[3]; eb = d[2];
      end else begin
         pg = 1; n = 2;
         if (d[1:0] == 2'b01) a2 = {d[31:10], va[19:12], 2'b00};
         else                 a2 = {d[31:12], va[19:10], 2'b00};
         e = rd(a2);
         if (e[1:0] == 2'b00) begin ef = 3'd2; return; end
         if (e[1:0] == 2'b01) begin
            epa = {e[31:16], va[15:0]}; apf = e[4 + 2*int'(va[15:14]) +: 2];
         end else if (e[1:0] == 2'b10) begin
            epa = {e[31:12], va[11:0]}; apf = e[4 + 2*int'(va[11:10]) +: 2];
         end else begin
            epa = {e[31:10], va[9:0]}; apf = e[5:4];
         end
         ec = e[3]; eb = e[2];
      end
      dc = dacr[2*dm +: 2];
      if (dc == 2'b00 || dc == 2'b10) ef = pg ? 3'd4 : 3'd3;
      else if (dc == 2'b01) begin
         ok = (apf == 2'b11) || (apf == 2'b10 && (pr || !wr)) ||
              (apf == 2'b01 && pr) || (apf == 2'b00 && pr && !wr);
         if (!ok) ef = pg ? 3'd6 : 3'd5;
      end
      if (ef != 0) begin epa = 0; ec = 0; eb = 0; end
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // memory responder with rotating stall and latency
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         mem_req_ready <= 1'b0;
         mem_rsp_valid <= 1'b0;
         mem_rsp_data  <= '0;
         pend          <= 0;
      end else begin
         mem_req_ready <= (cyc % 5) != 3;
         mem_rsp_valid <= 1'b0;
         if (pend) begin
            if (lat == 0) begin
               mem_rsp_valid <= 1'b1;
               mem_rsp_data  <= hold;
               pend          <= 0;
            end else begin
               lat <= lat - 1;
            end
         end
         if (mem_req_valid && mem_req_ready) begin
            addr_q.push_back(mem_req_addr);
            hold <= rd(mem_req_addr);
            lat  <= cyc % 3;
            pend <= 1;
         end
      end
   end

   // per-cycle monitor of the result strobe (R10)
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && done_prev) chk("R10", "done held twice", 32'(done), 32'h0);
         done_prev <= done;
      end else begin
         done_prev <= 1'b0;
      end
   end

   task automatic walk(input logic [31:0] va, input bit wr, input bit pr,
                       input bit junk, input string tag);
      logic [31:0] epa, a1, a2;
      bit          ec, eb;
      logic [2:0]  ef;
      int          n, t;
      ref_walk(va, wr, pr, epa, ec, eb, ef, a1, a2, n);
      addr_q.delete();
      @(negedge clk);
      chk("R9", "ready before request", 32'(req_ready), 32'h1);
      req_valid = 1'b1; req_va = va; req_write = wr; req_priv = pr;
      @(negedge clk);
      if (junk) begin
         req_va = ~va; req_write = ~wr; req_priv = ~pr;
      end else begin
         req_valid = 1'b0;
      end
      t = 0;
      while (done !== 1'b1 && t < 300) begin
         @(negedge clk);
         t++;
      end
      req_valid = 1'b0;
      if (t >= 300) begin
         chk(tag, "watchdog", 32'h0, 32'h1);
         return;
      end
      chk(tag, "pa", pa, epa);
      chk(tag, "cacheable R5", 32'(cacheable), 32'(ec));
      chk(tag, "bufferable R5", 32'(bufferable), 32'(eb));
      chk(tag, "fault", 32'(fault_code), 32'(ef));
      chk(tag, "read count", 32'(addr_q.size()), 32'(n));
      if (addr_q.size() >= 1) chk("R1", "first read address", addr_q[0], a1);
      if (n == 2 && addr_q.size() >= 2) chk("R3", "second read address", addr_q[1], a2);
      @(negedge clk);
      chk("R10", "done after one cycle", 32'(done), 32'h0);
      chk("R10", "ready after done", 32'(req_ready), 32'h1);
      if (junk) begin
         repeat (3) @(negedge clk);
         chk("R9", "no walk from busy request", 32'(mem_req_valid), 32'h0);
         chk("R9", "no extra reads", 32'(addr_q.size()), 32'(n));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk("WDOG", "global watchdog", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_priv = 1'b0;
      tbase = TB;
      dacr  = '0;
      dacr[2*1 +: 2] = 2'b01;
      dacr[2*2 +: 2] = 2'b01;
      dacr[2*3 +: 2] = 2'b01;
      dacr[2*5 +: 2] = 2'b11;
      dacr[2*6 +: 2] = 2'b10;

      mem[TB + 4*1] = mk_l1(2'b10, 32'hABC0_0000, 1, 2'b11, 1, 0);
      mem[TB + 4*2] = mk_l1(2'b01, CB, 2, 2'b00, 0, 0);
      mem[TB + 4*3] = mk_l1(2'b11, FB, 3, 2'b00, 0, 0);
      mem[TB + 4*4] = mk_l1(2'b10, 32'h1230_0000, 0, 2'b11, 1, 1);
      mem[TB + 4*5] = mk_l1(2'b10, 32'h4560_0000, 5, 2'b00, 0, 1);
      mem[TB + 4*6] = mk_l1(2'b10, 32'h7890_0000, 6, 2'b11, 1, 1);
      mem[TB + 4*7] = mk_l1(2'b10, 32'hCDE0_0000, 1, 2'b00, 1, 1);
      mem[TB + 4*8] = mk_l1(2'b10, 32'hF010_0000, 1, 2'b10, 0, 1);
      for (int q = 0; q < 4; q++)
         mem[CB + 32'(16*q)] = mk_l2(2'b01, 32'h5555_0000, 8'b11_10_01_00, 1, 1);
      mem[CB + 4*1] = mk_l2(2'b10, 32'h6666_6000, 8'b10_01_00_11, 0, 1);
      mem[CB + 4*3] = mk_l2(2'b11, 32'h7777_7C00, 8'b00_00_00_10, 1, 0);
      mem[FB + 4*0] = mk_l2(2'b11, 32'h8888_8400, 8'b00_00_00_01, 1, 1);
      mem[FB + 4*5] = mk_l2(2'b10, 32'h9999_9000, 8'b11_11_11_11, 1, 0);

      repeat (3) @(negedge clk);
      chk("RST", "ready in reset", 32'(req_ready), 32'h1);
      chk("RST", "done in reset", 32'(done), 32'h0);
      chk("RST", "mem request in reset", 32'(mem_req_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("RST", "fault code after reset", 32'(fault_code), 32'h0);

      walk(32'h0001_2345, 0, 1, 0, "R2 section translation fault");
      walk(32'h001F_FFFF, 1, 0, 0, "R2 R5 section client full access");
      walk(32'h0071_0000, 0, 1, 0, "R7 section ap00 priv read");
      walk(32'h0071_0004, 1, 1, 0, "R7 section ap00 priv write");
      walk(32'h0071_0008, 0, 0, 0, "R7 section ap00 user read");
      walk(32'h0080_1234, 0, 0, 0, "R7 section ap10 user read");
      walk(32'h0080_1234, 1, 0, 0, "R7 section ap10 user write");
      walk(32'h0080_5678, 1, 1, 0, "R7 section ap10 priv write");
      walk(32'h0040_0000, 0, 1, 0, "R6 R8 domain no access");
      walk(32'h0050_ABCD, 1, 0, 0, "R6 manager bypass");
      walk(32'h0060_0010, 0, 1, 0, "R6 reserved domain");
      walk(32'h0020_0123, 0, 0, 0, "R4 R7 large quarter 0 user read");
      walk(32'h0020_4123, 1, 1, 0, "R4 R7 large quarter 1 priv write");
      walk(32'h0020_8FFF, 0, 0, 0, "R4 R7 large quarter 2 user read");
      walk(32'h0020_8FFF, 1, 0, 0, "R4 R7 large quarter 2 user write");
      walk(32'h0020_C123, 1, 0, 0, "R4 R7 large quarter 3 user write");
      walk(32'h0020_1000, 1, 0, 0, "R4 R7 small quarter 0 user write");
      walk(32'h0020_1400, 0, 1, 0, "R4 R7 small quarter 1 priv read");
      walk(32'h0020_1400, 0, 0, 0, "R4 R7 small quarter 1 user read");
      walk(32'h0020_1C00, 0, 0, 0, "R4 R7 small quarter 3 user read");
      walk(32'h0020_2000, 0, 1, 0, "R4 R8 coarse page translation fault");
      walk(32'h0020_33FF, 0, 0, 0, "R3 R4 tiny page in coarse table");
      walk(32'h0030_02AB, 1, 1, 0, "R3 R4 fine tiny priv write");
      walk(32'h0030_02AB, 0, 0, 0, "R3 R7 fine tiny user read");
      walk(32'h0030_1555, 1, 0, 0, "R3 R5 fine small page");
      walk(32'h0030_1800, 0, 1, 0, "R3 R4 fine page translation fault");
      walk(32'h001A_BCDE, 0, 1, 1, "R9 R11 request during walk");
      walk(32'h0030_1555, 0, 1, 1, "R9 request during page walk");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule